// File: doc/BRIEF.md
# Multichannel ADC Readout Demultiplexer

This block sits between a four-channel, simultaneous-sampling converter and the logic that consumes one of its channels. When the converter pulls its active-low end-of-conversion line low, the block runs a fixed read burst on the system clock. The burst has four active-low read strobes, one for each channel result, delivered in channel order. The converter chip-select is held low for the whole burst.

The block numbers the strobes as they go out and compares that number with a two-bit channel select. That select is sampled once, when the burst starts. The latch enable is raised only during the matching strobe. The data bus is captured into the output register on the last low cycle of that strobe. The stored word keeps its 12-bit two's-complement bit pattern unchanged. The cycle after capture, a one-cycle valid pulse marks the new word.

An end-of-conversion edge that arrives while a burst is still running is dropped, and a sticky overrun flag is set.

Top module: `adc_readout_demux`

## Requirements
- R1: After reset, cs_n and rd_n are 1, latch_en, dout_valid and overrun are 0, and dout is 0.
- R2: A burst starts only on a falling edge of eoc_n. Holding eoc_n low starts no further burst.
- R3: Every burst has exactly four rd_n low strobes. Each strobe is low for 2 cycles, and consecutive strobes are separated by exactly 1 high cycle.
- R4: cs_n is low for exactly 11 consecutive cycles per burst, and rd_n is never low while cs_n is high.
- R5: latch_en is high only during one strobe of the burst: the strobe whose 0-based index equals the select code, so that code 00 picks the first strobe and code 11 picks the fourth. It is high for all 2 cycles of that strobe and for no other cycle.
- R6: dout takes the 12-bit data value present on the bus during the last low cycle of the selected strobe, bit for bit, including negative values.
- R7: dout_valid pulses high for exactly one cycle per burst, in the cycle after capture. dout does not change in any cycle where dout_valid is low.
- R8: The select code is sampled when the burst starts. A change of sel during the burst does not alter which strobe is captured.
- R9: A falling edge of eoc_n during a burst leaves the burst unchanged and sets overrun. overrun stays set until reset and is 0 while no such edge has occurred.
- R10: The strobe counter restarts at channel 1 on every new burst: the first strobe begins in the same cycle cs_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobe timing derives from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| eoc_n | input | 1 | Active-low end-of-conversion from the converter (synchronized inside) |
| sel | input | 2 | Binary channel select, 00 = channel 1 … 11 = channel 4 |
| adc_data | input | 12 | Converter data bus |
| cs_n | output | 1 | Active-low converter chip-select, low for the whole burst |
| rd_n | output | 1 | Active-low read strobe |
| latch_en | output | 1 | High during the strobe of the selected channel |
| dout | output | 12 | Captured sample of the selected channel |
| dout_valid | output | 1 | One-cycle pulse after a new word is captured |
| overrun | output | 1 | Sticky flag: end of conversion seen while busy |

## Verification
The hardest situations to reach are the ones where an input changes while a burst is running: a second end-of-conversion edge, and a select change after the burst has sampled the code. The bench drives eoc_n and sel from a cycle counter that runs inside the burst monitor. This places a fresh falling edge, or a new select code, several cycles into the burst. The bench then checks that the strobe pattern, the captured word and the flags match a burst that was not disturbed. Another case holds eoc_n low across the whole window, to show that a level does not retrigger the block.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;

  // Cycles that chip-select spends low for one burst.
  function automatic int unsigned burst_len(int unsigned n_ch, int unsigned lo, int unsigned gap);
    return n_ch * lo + (n_ch - 1) * gap;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eoc_edge.sv
module eoc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_n,
  output logic fall_evt
);
  // sh[0..SYNC_STAGES-1] synchronize, sh[SYNC_STAGES] holds the previous value
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC_STAGES-1:0], eoc_n};
  end

  assign fall_evt = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  assert_one_cycle_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import adc_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RD_LOW = 2,
  parameter int RD_GAP = 1,
  localparam int CNT_W = $clog2(NUM_CH),
  localparam int PH_W  = $clog2(max2(RD_LOW, RD_GAP) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic [CNT_W-1:0] sel,
  output logic             rd_n,
  output logic             cs_n,
  output logic [CNT_W-1:0] strobe_idx,
  output logic [CNT_W-1:0] sel_q,
  output logic             cap_evt,
  output logic             overrun_evt
);
  seq_state_t      state;
  logic [PH_W-1:0] ph;

  localparam logic [PH_W-1:0]  LOW_LAST = PH_W'(RD_LOW - 1);
  localparam logic [PH_W-1:0]  GAP_LAST = PH_W'(RD_GAP - 1);
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(NUM_CH - 1);

  logic busy;
  assign busy = (state != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      ph         <= '0;
      strobe_idx <= '0;
      sel_q      <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (start_evt) begin
          state      <= SEQ_LOW;
          ph         <= '0;
          strobe_idx <= '0;
          sel_q      <= sel;
        end
        SEQ_LOW: begin
          if (ph == LOW_LAST) begin
            ph    <= '0;
            state <= (strobe_idx == IDX_LAST) ? SEQ_IDLE : SEQ_GAP;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (ph == GAP_LAST) begin
            ph         <= '0;
            state      <= SEQ_LOW;
            strobe_idx <= strobe_idx + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_n        = (state != SEQ_LOW);
  assign cs_n        = !busy;
  assign cap_evt     = (state == SEQ_LOW) && (ph == LOW_LAST);
  assign overrun_evt = start_evt && busy;

  assert_rd_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  assert_strobe_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);
  assert_gap_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) && !cs_n) |=> $fell(rd_n));
  assert_restart_ch1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (strobe_idx == '0 && !rd_n));
  assert_sel_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$fell(cs_n)) |-> $stable(sel_q));

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_strobe,
  input  logic [CNT_W-1:0]  strobe_idx,
  input  logic [CNT_W-1:0]  sel_q,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] din,
  output logic              latch_en,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  assign latch_en = in_strobe && (strobe_idx == sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= latch_en && cap_evt;
      if (latch_en && cap_evt) dout <= din;
    end
  end

  assert_latch_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> in_strobe);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);
  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> $stable(dout));
  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && cap_evt) |=> (dout == $past(din)));

endmodule

// File: rtl/adc_readout_demux.sv
module adc_readout_demux
  import adc_demux_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NUM_CH      = 4,
  parameter int RD_LOW      = 2,
  parameter int RD_GAP      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eoc_n,
  input  logic [$clog2(NUM_CH)-1:0]  sel,
  input  logic [DATA_W-1:0]          adc_data,
  output logic                       cs_n,
  output logic                       rd_n,
  output logic                       latch_en,
  output logic [DATA_W-1:0]          dout,
  output logic                       dout_valid,
  output logic                       overrun
);
  localparam int CNT_W  = $clog2(NUM_CH);
  localparam int BURST  = int'(burst_len(NUM_CH, RD_LOW, RD_GAP));
  localparam int CSC_W  = $clog2(BURST + 2);

  logic             start_evt;
  logic             overrun_evt;
  logic             cap_evt;
  logic [CNT_W-1:0] strobe_idx;
  logic [CNT_W-1:0] sel_q;

  eoc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .eoc_n    (eoc_n),
    .fall_evt (start_evt)
  );

  strobe_seq #(.NUM_CH(NUM_CH), .RD_LOW(RD_LOW), .RD_GAP(RD_GAP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .sel         (sel),
    .rd_n        (rd_n),
    .cs_n        (cs_n),
    .strobe_idx  (strobe_idx),
    .sel_q       (sel_q),
    .cap_evt     (cap_evt),
    .overrun_evt (overrun_evt)
  );

  capture_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_strobe  (!rd_n),
    .strobe_idx (strobe_idx),
    .sel_q      (sel_q),
    .cap_evt    (cap_evt),
    .din        (adc_data),
    .latch_en   (latch_en),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (overrun_evt) overrun <= 1'b1;
  end

  // Length of the current chip-select window, kept for the assertions below.
  logic [CSC_W-1:0] cs_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_low_cnt <= '0;
    else if (!cs_n) cs_low_cnt <= cs_low_cnt + 1'b1;
    else            cs_low_cnt <= '0;
  end

  assert_cs_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_low_cnt <= CSC_W'(BURST));
  assert_cs_full_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (cs_low_cnt == CSC_W'(BURST)));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !cs_n) |=> overrun);

endmodule

// File: tb/sim_adc_readout_demux.sv
`timescale 1ns/1ps
module sim_adc_readout_demux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eoc_n = 1'b1;
  logic [1:0]  sel = 2'd0;
  logic [11:0] adc_data = 12'h5A5;
  logic        cs_n, rd_n, latch_en, dout_valid, overrun;
  logic [11:0] dout;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_readout_demux u0 (
    .clk(clk), .rst_n(rst_n), .eoc_n(eoc_n), .sel(sel), .adc_data(adc_data),
    .cs_n(cs_n), .rd_n(rd_n), .latch_en(latch_en), .dout(dout),
    .dout_valid(dout_valid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Word the modelled converter puts on the bus for channel ch (0..3) in pattern p.
  function automatic logic [11:0] word(int p, int ch);
    case (p % 4)
      0: return 12'(12'h800 + ch);
      1: return 12'(12'h7FF - ch);
      2: return 12'((p * 917 + ch * 301 + 5) % 4096);
      default: return 12'(12'hFFF - 2 * ch);
    endcase
  endfunction

  // One burst: s = select, p = data pattern, mid_sel/hold/ovr modify the stimulus.
  task automatic burst(input int s, input int p, input bit mid_sel, input bit hold, input bit ovr);
    int strobes = 0, cs_low = 0, latch_cyc = 0, latch_bad = 0, vcount = 0;
    int lowlen = 0, gaplen = 0, len_bad = 0, gap_bad = 0, first_ok = 1;
    bit prev_rd = 1, prev_cs = 1;
    logic [11:0] got = 12'h0;
    logic [11:0] exp_w = word(p, s);
    @(negedge clk);
    sel = 2'(s);
    eoc_n = 1'b0;
    for (int c = 0; c < 26; c++) begin
      @(negedge clk);
      if (c == 3 && !hold) eoc_n = 1'b1;
      if (c == 8 && mid_sel) sel = 2'(s) ^ 2'b11;
      if (c == 8 && ovr) eoc_n = 1'b0;
      if (c == 10 && ovr) eoc_n = 1'b1;
      if (!cs_n) cs_low++;
      if (!cs_n && prev_cs && rd_n) first_ok = 0;
      if (!rd_n && prev_rd) begin
        strobes++;
        if (gaplen != 0 && gaplen != 1) gap_bad++;
        lowlen = 0;
      end
      if (rd_n && !prev_rd) begin
        if (lowlen != 2) len_bad++;
        gaplen = 0;
      end
      if (!rd_n) lowlen++;
      if (rd_n && !cs_n) gaplen++;
      if (latch_en) begin
        latch_cyc++;
        if (strobes != s + 1 || rd_n) latch_bad++;
      end
      if (dout_valid) begin vcount++; got = dout; end
      adc_data = (!rd_n && strobes >= 1) ? word(p, strobes - 1) : 12'h5A5;
      prev_rd = rd_n;
      prev_cs = cs_n;
    end
    eoc_n = 1'b1;
    adc_data = 12'h5A5;
    repeat (4) @(negedge clk);
    check(strobes == 4, "R3", "strobe count", strobes, 4);
    check(len_bad == 0 && gap_bad == 0, "R3", "strobe/gap length errors", len_bad + gap_bad, 0);
    check(cs_low == 11, "R4", "cs_n low cycles", cs_low, 11);
    check(latch_cyc == 2 && latch_bad == 0, "R5", "latch cycles (bad)", latch_cyc * 16 + latch_bad, 32);
    check(vcount == 1, "R7", "valid pulses", vcount, 1);
    check(got == exp_w, mid_sel ? "R8" : "R6", "captured word", got, exp_w);
    check(dout == exp_w, "R7", "dout held after burst", dout, exp_w);
    check(first_ok == 1, "R10", "first strobe at cs fall", first_ok, 1);
    if (hold) check(strobes == 4, "R2", "held eoc_n retrigger", strobes, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && rd_n && !latch_en && !dout_valid && !overrun && dout == 0, "R1",
          "reset outputs", {cs_n, rd_n, latch_en, dout_valid, overrun}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && rd_n, "R2", "no burst without eoc edge", {cs_n, rd_n}, 2'b11);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        burst(s, p, 0, 0, 0);
        check(overrun == 0, "R9", "overrun clear in normal bursts", overrun, 0);
      end
    burst(2, 1, 1, 0, 0);
    burst(0, 2, 1, 0, 0);
    burst(1, 3, 0, 1, 0);
    repeat (10) @(negedge clk);
    check(cs_n == 1, "R2", "idle while eoc_n stays high after hold", cs_n, 1);
    burst(3, 0, 0, 0, 1);
    check(overrun == 1, "R9", "overrun set by edge in burst", overrun, 1);
    repeat (12) @(negedge clk);
    check(cs_n == 1, "R9", "ignored edge started no burst", cs_n, 1);
    burst(1, 2, 0, 0, 0);
    check(overrun == 1, "R9", "overrun sticky", overrun, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule